// File: doc/BRIEF.md
# Processor Status Register with Per-Thread Mirror

This block is the control-register slice that owns the 32-bit processor Status word. A software write arrives as a one-cycle strobe with a data word. Only the bits allowed by a writable-bit mask change. The mask comes in on a configuration input. When a revision-6 mode flag is set, the mask also depends on the data being written. A privilege-mode code of 3 is dropped when both mode bits are writable. The SR and NMI flags may be cleared by writing 0, but a written 1 leaves them as they were.

When the multithreading flag is set, each Status write also updates a per-thread TCStatus word in the same clock edge. The TCStatus word receives the coprocessor-usable bits, the MX bit, the privilege-mode bits and the low byte of a separate address-space-ID source. If the target thread index equals the current thread index, the write goes to the active-thread TCStatus register. Otherwise it goes to the indexed entry of a thread-context array. The decoded privilege mode is a combinational output taken from the stored Status word.

Top module: `cp_status_slice`

## Requirements
- R1: On a write, Status bit n takes the written bit n when effective-mask bit n is 1 and keeps its old value otherwise; with no write, Status holds.
- R2: With revision-6 mode set, the Status mask has bits 4:3 (the KSU field) both set, and the written KSU field equals 3, that write leaves Status[4:3] unchanged.
- R3: With revision-6 mode set, writing 1 to SR (bit 20) or NMI (bit 19) leaves that bit unchanged, while writing 0 clears it when it is writable.
- R4: With multithreading set, the write places the new Status CU (bits 31:28) at TCStatus 31:28, Status MX (bit 24) at TCStatus 27, and Status KSU (bits 4:3) at TCStatus 12:11.
- R5: The TCStatus bits 7:0 written with a Status write come from the address-space-ID input sampled in that write cycle.
- R6: TCStatus bits outside 31:27, 12:11 and 7:0 are never changed by a mirror update, so they stay 0 from reset.
- R7: The mirror goes to the active TCStatus output when the target index equals the current index; otherwise it goes to array entry [target]. The entry at the current index and all other entries are untouched.
- R8: With multithreading clear, a Status write changes neither the active TCStatus nor any array entry.
- R9: The privilege mode output is 0 (kernel) when EXL (bit 1) or ERL (bit 2) is set. Otherwise it is 0 for KSU 0, 1 (supervisor) for KSU 1, and 2 (user) for KSU 2 or 3.
- R10: Reset loads Status with 32'h0000_0004 (ERL only) and clears the active TCStatus and every array entry.
- R11: With revision-6 mode clear, KSU = 3, SR = 1 and NMI = 1 are written like any other masked bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 32 | Value written to Status |
| wr_mask | input | 32 | Configured writable bits of Status |
| rev6_en | input | 1 | Enables data-dependent write rules |
| mt_en | input | 1 | Enables TCStatus mirroring |
| cur_tc | input | TCW | Index of the running thread |
| tgt_tc | input | TCW | Thread whose TCStatus is updated |
| asid_in | input | 8 | Address-space ID from the separate register |
| status_q | output | 32 | Current Status word |
| active_tcst | output | 32 | Active-thread TCStatus |
| tcst_bank | output | NTC*32 | Thread-context TCStatus array, entry i at bits i*32 +: 32 |
| priv_mode | output | 2 | Decoded privilege mode |

## Verification
Two functions can act on the same write cycle. The data-dependent mask rules change what Status becomes, and the mirror copies that new Status into TCStatus in the same edge. A wrong design could therefore mirror the old value or the value before masking. The bench provokes this with revision-6 writes that carry KSU = 3 or SR/NMI set while multithreading is on. It mixes in random target and current indices. Every output word is compared after each write against a bench model that first applies the mask rules and then builds the mirror image from the result.

// File: rtl/cpst_pkg.sv
package cpst_pkg;
  localparam int ST_W = 32;
  // Status field positions
  localparam int ST_CU_LO = 28;
  localparam int ST_MX    = 24;
  localparam int ST_SR    = 20;
  localparam int ST_NMI   = 19;
  localparam int ST_KSU_LO = 3;
  localparam int ST_ERL   = 2;
  localparam int ST_EXL   = 1;
  // TCStatus field positions
  localparam int TC_CU_LO  = 28;
  localparam int TC_MX     = 27;
  localparam int TC_KSU_LO = 11;
  localparam int ASID_W    = 8;
  localparam logic [ST_W-1:0] TC_FIELD_MASK = 32'hF800_18FF;
  localparam logic [ST_W-1:0] ST_RESET = 32'h0000_0004;

  typedef enum logic [1:0] {
    PM_KERNEL = 2'd0,
    PM_SUPER  = 2'd1,
    PM_USER   = 2'd2
  } priv_e;
endpackage

// File: rtl/cpst_wmask.sv
module cpst_wmask
  import cpst_pkg::*;
(
  input  logic [ST_W-1:0] cfg_mask,
  input  logic            rev6,
  input  logic [1:0]      data_ksu,
  input  logic            data_sr,
  input  logic            data_nmi,
  output logic [ST_W-1:0] eff_mask
);
  logic ksu_both;

  always_comb begin
    ksu_both = (cfg_mask[ST_KSU_LO +: 2] == 2'b11);
    eff_mask = cfg_mask;
    if (rev6) begin
      if (ksu_both && (data_ksu == 2'b11)) begin
        eff_mask[ST_KSU_LO +: 2] = 2'b00;
      end
      if (data_sr) begin
        eff_mask[ST_SR] = 1'b0;
      end
      if (data_nmi) begin
        eff_mask[ST_NMI] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cpst_mode_dec.sv
module cpst_mode_dec
  import cpst_pkg::*;
(
  input  logic [1:0] ksu,
  input  logic       exl,
  input  logic       erl,
  output priv_e      mode
);
  always_comb begin
    if (exl || erl) begin
      mode = PM_KERNEL;
    end else begin
      unique case (ksu)
        2'd0:    mode = PM_KERNEL;
        2'd1:    mode = PM_SUPER;
        default: mode = PM_USER;
      endcase
    end
  end
endmodule

// File: rtl/cpst_tc_bank.sv
module cpst_tc_bank
  import cpst_pkg::*;
#(
  parameter int NTC = 4,
  parameter int TCW = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              to_active,
  input  logic [TCW-1:0]    idx,
  input  logic [ST_W-1:0]   image,
  output logic [ST_W-1:0]   active_q,
  output logic [NTC*ST_W-1:0] bank_q
);
  logic [ST_W-1:0] active_d;
  logic            active_en;

  always_comb begin
    active_en = upd_en && to_active;
    active_d  = (active_q & ~TC_FIELD_MASK) | (image & TC_FIELD_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (active_en) begin
      active_q <= active_d;
    end
  end

  for (genvar i = 0; i < NTC; i++) begin : g_ent
    logic [ST_W-1:0] ent_q;
    logic [ST_W-1:0] ent_d;
    logic            ent_en;

    always_comb begin
      ent_en = upd_en && !to_active && (idx == TCW'(i));
      ent_d  = (ent_q & ~TC_FIELD_MASK) | (image & TC_FIELD_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ent_en) begin
        ent_q <= ent_d;
      end
    end

    assign bank_q[i*ST_W +: ST_W] = ent_q;
  end
endmodule

// File: rtl/cp_status_slice.sv
module cp_status_slice
  import cpst_pkg::*;
#(
  parameter int NTC = 4,
  localparam int TCW = (NTC > 1) ? $clog2(NTC) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic [31:0]       wr_mask,
  input  logic              rev6_en,
  input  logic              mt_en,
  input  logic [TCW-1:0]    cur_tc,
  input  logic [TCW-1:0]    tgt_tc,
  input  logic [7:0]        asid_in,
  output logic [31:0]       status_q,
  output logic [31:0]       active_tcst,
  output logic [NTC*32-1:0] tcst_bank,
  output logic [1:0]        priv_mode
);
  logic [ST_W-1:0] eff_mask;
  logic [ST_W-1:0] status_d;
  logic [ST_W-1:0] tc_image;
  logic            mirror_en;
  priv_e           mode_s;

  cpst_wmask u_wmask (
    .cfg_mask (wr_mask),
    .rev6     (rev6_en),
    .data_ksu (wr_data[ST_KSU_LO +: 2]),
    .data_sr  (wr_data[ST_SR]),
    .data_nmi (wr_data[ST_NMI]),
    .eff_mask (eff_mask)
  );

  // next-state for Status and the mirror image built from it
  always_comb begin
    status_d  = (status_q & ~eff_mask) | (wr_data & eff_mask);
    mirror_en = wr_en && mt_en;
    tc_image  = '0;
    tc_image[TC_CU_LO +: 4]  = status_d[ST_CU_LO +: 4];
    tc_image[TC_MX]          = status_d[ST_MX];
    tc_image[TC_KSU_LO +: 2] = status_d[ST_KSU_LO +: 2];
    tc_image[ASID_W-1:0]     = asid_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= ST_RESET;
    end else if (wr_en) begin
      status_q <= status_d;
    end
  end

  cpst_tc_bank #(.NTC(NTC), .TCW(TCW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (mirror_en),
    .to_active (tgt_tc == cur_tc),
    .idx       (tgt_tc),
    .image     (tc_image),
    .active_q  (active_tcst),
    .bank_q    (tcst_bank)
  );

  cpst_mode_dec u_dec (
    .ksu  (status_q[ST_KSU_LO +: 2]),
    .exl  (status_q[ST_EXL]),
    .erl  (status_q[ST_ERL]),
    .mode (mode_s)
  );

  assign priv_mode = mode_s;
endmodule

// File: rtl/cpst_checker.sv
module cpst_checker #(
  parameter int NTC = 4,
  parameter int TCW = 2
)(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic [31:0]       wr_mask,
  input logic              rev6_en,
  input logic              mt_en,
  input logic [TCW-1:0]    cur_tc,
  input logic [TCW-1:0]    tgt_tc,
  input logic [7:0]        asid_in,
  input logic [31:0]       status_q,
  input logic [31:0]       active_tcst,
  input logic [NTC*32-1:0] tcst_bank,
  input logic [1:0]        priv_mode
);
  p_masked_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((status_q ^ $past(status_q)) & ~$past(wr_mask)) == 32'h0);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(status_q));

  p_ksu_rsv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rev6_en && wr_mask[4:3] == 2'b11 && wr_data[4:3] == 2'b11)
      |=> $stable(status_q[4:3]));

  p_sr_noset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rev6_en && wr_data[20]) |=> $stable(status_q[20]));

  p_nmi_noset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rev6_en && wr_data[19]) |=> $stable(status_q[19]));

  p_mirror_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mt_en && tgt_tc == cur_tc) |=>
      (active_tcst[31:28] == status_q[31:28] && active_tcst[27] == status_q[24]
       && active_tcst[12:11] == status_q[4:3]));

  p_mirror_asid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mt_en && tgt_tc == cur_tc) |=> active_tcst[7:0] == $past(asid_in));

  p_tc_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_tcst & 32'h07FF_E700) == 32'h0);

  p_bank_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mt_en && tgt_tc == cur_tc) |=> $stable(tcst_bank));

  p_active_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mt_en && tgt_tc != cur_tc) |=> $stable(active_tcst));

  p_no_mt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && mt_en) |=> ($stable(active_tcst) && $stable(tcst_bank)));

  p_exc_kernel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[2] || status_q[1]) |-> priv_mode == 2'd0);

  p_mode_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    priv_mode != 2'd3);
endmodule

bind cp_status_slice cpst_checker #(.NTC(NTC), .TCW(TCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .wr_mask(wr_mask), .rev6_en(rev6_en), .mt_en(mt_en), .cur_tc(cur_tc),
  .tgt_tc(tgt_tc), .asid_in(asid_in), .status_q(status_q),
  .active_tcst(active_tcst), .tcst_bank(tcst_bank), .priv_mode(priv_mode)
);

// File: tb/sim_cp_status_slice.sv
module sim_cp_status_slice;
  localparam int NTC = 4;
  localparam int TCW = 2;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [31:0]       wr_data;
  logic [31:0]       wr_mask;
  logic              rev6_en;
  logic              mt_en;
  logic [TCW-1:0]    cur_tc;
  logic [TCW-1:0]    tgt_tc;
  logic [7:0]        asid_in;
  logic [31:0]       status_q;
  logic [31:0]       active_tcst;
  logic [NTC*32-1:0] tcst_bank;
  logic [1:0]        priv_mode;

  int n_cmp;
  int n_bad;

  logic [31:0] m_st;
  logic [31:0] m_act;
  logic [31:0] m_bank [NTC];

  cp_status_slice #(.NTC(NTC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_mask(wr_mask), .rev6_en(rev6_en), .mt_en(mt_en), .cur_tc(cur_tc),
    .tgt_tc(tgt_tc), .asid_in(asid_in), .status_q(status_q),
    .active_tcst(active_tcst), .tcst_bank(tcst_bank), .priv_mode(priv_mode)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] f_mask(logic [31:0] m, logic [31:0] d, logic r6);
    logic [31:0] e = m;
    if (r6) begin
      if (m[4] && m[3] && d[4] && d[3]) begin e[4] = 1'b0; e[3] = 1'b0; end
      if (d[20]) e[20] = 1'b0;
      if (d[19]) e[19] = 1'b0;
    end
    return e;
  endfunction

  function automatic logic [31:0] f_merge(logic [31:0] old, logic [31:0] st, logic [7:0] a);
    logic [31:0] r = old;
    r[31:28] = st[31:28];
    r[27]    = st[24];
    r[12:11] = st[4:3];
    r[7:0]   = a;
    return r;
  endfunction

  function automatic logic [1:0] f_mode(logic [31:0] st);
    if (st[1] || st[2]) return 2'd0;
    if (st[4:3] == 2'd0) return 2'd0;
    if (st[4:3] == 2'd1) return 2'd1;
    return 2'd2;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " status R1"}, status_q, m_st);
    chk({tag, " active R4"}, active_tcst, m_act);
    for (int i = 0; i < NTC; i++) chk({tag, " bank R7"}, tcst_bank[i*32 +: 32], m_bank[i]);
    chk({tag, " mode R9"}, {30'd0, priv_mode}, {30'd0, f_mode(m_st)});
  endtask

  task automatic do_wr(input logic [31:0] d, input logic [31:0] m, input logic r6,
                       input logic mt, input logic [TCW-1:0] cur, input logic [TCW-1:0] tgt,
                       input logic [7:0] a);
    logic [31:0] e;
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_mask = m; rev6_en = r6; mt_en = mt;
    cur_tc = cur; tgt_tc = tgt; asid_in = a;
    e = f_mask(m, d, r6);
    m_st = (m_st & ~e) | (d & e);
    if (mt) begin
      if (tgt == cur) m_act = f_merge(m_act, m_st, a);
      else m_bank[tgt] = f_merge(m_bank[tgt], m_st, a);
    end
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = $urandom;
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wr_mask = '0; rev6_en = 1'b0;
    mt_en = 1'b0; cur_tc = '0; tgt_tc = '0; asid_in = '0;
    m_st = 32'h0000_0004; m_act = '0;
    for (int i = 0; i < NTC; i++) m_bank[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 status reset", status_q, 32'h0000_0004);
    chk("R10 active reset", active_tcst, 32'h0);
    chk("R10 bank reset", tcst_bank[31:0] | tcst_bank[63:32] | tcst_bank[95:64] | tcst_bank[127:96], 32'h0);
    chk("R9 kernel at reset", {30'd0, priv_mode}, 32'd0);

    // R9: clear ERL, user then supervisor then reserved code
    do_wr(32'h0000_0010, 32'h0000_001E, 1'b0, 1'b0, 2'd0, 2'd0, 8'h00);
    chk("R9 user", {30'd0, priv_mode}, 32'd2);
    do_wr(32'h0000_0008, 32'h0000_001E, 1'b0, 1'b0, 2'd0, 2'd0, 8'h00);
    chk("R9 super", {30'd0, priv_mode}, 32'd1);
    // R11: KSU=3 and SR/NMI set accepted without rev6
    do_wr(32'h0018_0018, 32'hFFFF_FFF9, 1'b0, 1'b0, 2'd0, 2'd0, 8'h00);
    chk("R11 ksu3 sr nmi", status_q & 32'h0018_0018, 32'h0018_0018);
    chk("R9 reserved code user", {30'd0, priv_mode}, 32'd2);
    // R2: rev6 KSU=3 dropped with both writable; other bits still written
    do_wr(32'h0000_0008, 32'hFFFF_FFF9, 1'b0, 1'b0, 2'd0, 2'd0, 8'h00);
    do_wr(32'h3000_0018, 32'hFFFF_FFF9, 1'b1, 1'b1, 2'd1, 2'd1, 8'hA5);
    chk("R2 ksu kept", {30'd0, status_q[4:3]}, 32'd1);
    chk("R4 cu copied", {28'd0, active_tcst[31:28]}, 32'd3);
    chk("R5 asid", {24'd0, active_tcst[7:0]}, 32'hA5);
    // R2 corner: only one KSU bit writable -> code 3 not blocked
    do_wr(32'h0000_0018, 32'h0000_0010, 1'b1, 1'b0, 2'd0, 2'd0, 8'h00);
    chk("R2 single bit writable", {30'd0, status_q[4:3]}, 32'd3);
    // R3: SR/NMI set refused, cleared by 0
    do_wr(32'h0018_0000, 32'h0018_0000, 1'b0, 1'b0, 2'd0, 2'd0, 8'h00);
    do_wr(32'h0000_0000, 32'h0008_0000, 1'b1, 1'b0, 2'd0, 2'd0, 8'h00);
    chk("R3 nmi cleared", {31'd0, status_q[19]}, 32'd0);
    chk("R3 sr held", {31'd0, status_q[20]}, 32'd1);
    do_wr(32'h0018_0000, 32'h0018_0000, 1'b1, 1'b0, 2'd0, 2'd0, 8'h00);
    chk("R3 nmi not set", {31'd0, status_q[19]}, 32'd0);
    // R8: write with mt clear leaves TCStatus
    do_wr(32'hF100_0008, 32'hFFFF_FFFF, 1'b0, 1'b0, 2'd2, 2'd3, 8'h33);
    check_all("R8 no mirror");
    // R7: target differs from current
    do_wr(32'h5100_0010, 32'hFFFF_FFFF, 1'b0, 1'b1, 2'd0, 2'd2, 8'h7E);
    check_all("R7 indexed");
    chk("R6 rsvd bank", tcst_bank[64 +: 32] & 32'h07FF_E700, 32'h0);
    check_all("directed");

    for (int k = 0; k < 600; k++) begin
      logic [31:0] d;
      logic [31:0] m;
      d = $urandom;
      m = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
      if ($urandom_range(0, 3) == 0) d[4:3] = 2'b11;
      do_wr(d, m, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) != 0),
            TCW'($urandom_range(0, NTC - 1)), TCW'($urandom_range(0, NTC - 1)),
            8'($urandom));
      check_all("random");
      chk("R6 rsvd active", active_tcst & 32'h07FF_E700, 32'h0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule